// File: doc/BRIEF.md
# Downstream Repeat and Speed Gating for a Four-Port Hub

This block sits in the repeater path of a hub and decides, cycle by cycle, which downstream ports receive the traffic arriving from the upstream port, and whether a port's low-speed line drivers are active. It follows decoded packet events from an upstream receiver: a start-of-packet marker, a packet identifier byte with a strobe that marks it complete, an end-of-packet detect and a frame-start token indication. Each downstream port has two static flags, one saying it is enabled and one saying the attached device is low speed.

Full-speed packets are repeated onto enabled full-speed ports only. When a preamble identifier arrives inside a packet, the block waits a fixed number of full-speed bit ticks and then opens every enabled port, turning on the low-speed drivers of the low-speed ones. All of this closes again when the next end of packet is seen. A separate frame timer counts full-speed bit ticks and returns to zero on every frame-start token.

Top module: `hub_rpt_ctl`

## Requirements
- R1: During a full-speed packet (after a start-of-packet marker, before any preamble), `rpt_en[i]` is 1 exactly for ports with `port_en[i]=1` and `port_ls[i]=0`; a port with `port_ls[i]=1` never repeats while its low-speed drivers are off.
- R2: A port flagged low speed has `rpt_en` and `ls_drv_en` at 0 at all times except after a recognised preamble.
- R3: The preamble is recognised only when `pid_vld=1` while a full-speed packet is open and `pid` equals 8'h3C; any other byte, or 8'h3C without the strobe, leaves the outputs unchanged.
- R4: After the preamble strobe, the block counts `LS_GAP` (default 4, legal 1 to 4) cycles with `bit_tick=1`; one cycle after the last of them, every enabled port repeats and `ls_drv_en[i]=1` for enabled low-speed ports. Before that, low-speed ports stay closed.
- R5: One cycle after `eop=1`, all `rpt_en` and `ls_drv_en` bits are 0.
- R6: A port with `port_en[i]=0` has `rpt_en[i]=0` and `ls_drv_en[i]=0` regardless of its speed flag.
- R7: `frame_cnt` rises by one, modulo 2^`FRAME_W` (default 14), one cycle after each cycle with `bit_tick=1` and `sof_rx=0`; otherwise it holds.
- R8: One cycle after `sof_rx=1`, `frame_cnt` is 0, even when `bit_tick=1` in the same cycle.
- R9: A synchronous low `rst_n` closes every port, switches off all low-speed drivers and clears the frame timer.
- R10: A start-of-packet marker while a packet is already open has no effect; `eop` takes priority over `sop` and over the preamble strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per full-speed bit time |
| port_en | input | NPORTS | Per-port enable flag |
| port_ls | input | NPORTS | Per-port low-speed device flag |
| sop | input | 1 | Start of packet seen upstream |
| pid | input | 8 | Packet identifier byte with check nibble |
| pid_vld | input | 1 | Strobe: `pid` is complete |
| eop | input | 1 | End of packet seen upstream |
| sof_rx | input | 1 | Frame-start token received |
| rpt_en | output | NPORTS | Repeat upstream traffic onto this port |
| ls_drv_en | output | NPORTS | Low-speed drivers on for this port |
| frame_cnt | output | FRAME_W | Full-speed bit count since last frame start |

## Verification
Packet events and ticks act through one register, so their effect on `rpt_en`, `ls_drv_en` and `frame_cnt` is due one cycle after the edge that samples them, while the port flags reach `rpt_en` and `ls_drv_en` in the same cycle through combinational gating. The bench drives inputs at the falling edge, compares outputs one time step later against a model that it advances only at the next rising edge, so each comparison sees exactly the state built from stimuli already sampled. The low-speed opening is checked in the cycle after the fourth counted tick and in every cycle before it.

// File: rtl/hub_rpt_pkg.sv
// Shared types for the hub repeat-control block.
// Assumes: identifier bytes carry the check nibble in the upper four bits.
package hub_rpt_pkg;

    // Repeat sequencer states: closed, full-speed open, waiting after preamble, low-speed open.
    typedef enum logic [1:0] {
        RS_IDLE     = 2'd0,
        RS_FS       = 2'd1,
        RS_PRE_WAIT = 2'd2,
        RS_LS       = 2'd3
    } rpt_state_e;

    // Preamble identifier: code 4'b1100 with its inverted copy as check nibble.
    localparam logic [7:0] PRE_PID_BYTE = 8'h3C;

endpackage

// File: rtl/rpt_seq.sv
// Packet sequencer: tracks whether a packet is open, detects the preamble
// identifier and times the delay before low-speed ports open.
// Assumes: sop/pid_vld/eop are single-cycle pulses already aligned to clk;
// LS_GAP lies between 1 and 4.
module rpt_seq
    import hub_rpt_pkg::*;
#(
    parameter int LS_GAP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       sop,
    input  logic [7:0] pid,
    input  logic       pid_vld,
    input  logic       eop,
    output logic       fs_open,
    output logic       ls_open
);

    localparam int GAP_W = (LS_GAP < 2) ? 1 : $clog2(LS_GAP);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LS_GAP - 1);

    rpt_state_e       state_q;
    logic [GAP_W-1:0] gap_q;
    logic             pre_hit;

    // Preamble is only taken from a completed identifier byte.
    assign pre_hit = pid_vld && (pid == PRE_PID_BYTE);

    // Advance the packet state; end of packet wins over every other event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            gap_q   <= '0;
        end else begin
            unique case (state_q)
                RS_IDLE: begin
                    if (sop && !eop) begin
                        state_q <= RS_FS;
                    end
                end
                RS_FS: begin
                    if (eop) begin
                        state_q <= RS_IDLE;
                    end else if (pre_hit) begin
                        state_q <= RS_PRE_WAIT;
                        gap_q   <= '0;
                    end
                end
                RS_PRE_WAIT: begin
                    if (eop) begin
                        state_q <= RS_IDLE;
                        gap_q   <= '0;
                    end else if (bit_tick) begin
                        if (gap_q == GAP_LAST) begin
                            state_q <= RS_LS;
                            gap_q   <= '0;
                        end else begin
                            gap_q <= gap_q + 1'b1;
                        end
                    end
                end
                RS_LS: begin
                    if (eop) begin
                        state_q <= RS_IDLE;
                    end
                end
                default: state_q <= RS_IDLE;
            endcase
        end
    end

    // Full-speed ports carry every open packet; low-speed ports only the opened tail.
    assign fs_open = (state_q != RS_IDLE);
    assign ls_open = (state_q == RS_LS);

    p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_PRE_WAIT) |-> (32'(gap_q) < LS_GAP));

    p_ls_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_open) |-> ($past(state_q) == RS_PRE_WAIT) && $past(bit_tick));

    p_eop_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> (!fs_open && !ls_open));

    p_no_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FS && !pid_vld && !eop) |=> (state_q == RS_FS));

    p_sop_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_LS && sop && !eop) |=> (state_q == RS_LS));

    p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q == RS_IDLE));

endmodule

// File: rtl/rpt_port_gate.sv
// Per-port gating: combines the sequencer's open flags with each port's
// enable and speed flags.
// Assumes: port flags are quasi-static and may act combinationally.
module rpt_port_gate #(
    parameter int NPORTS = 4
) (
    input  logic [NPORTS-1:0] port_en,
    input  logic [NPORTS-1:0] port_ls,
    input  logic              fs_open,
    input  logic              ls_open,
    output logic [NPORTS-1:0] rpt_en,
    output logic [NPORTS-1:0] ls_drv_en
);

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        // A low-speed port follows the low-speed window, others the packet window.
        always_comb begin
            rpt_en[g]    = port_en[g] && (port_ls[g] ? ls_open : fs_open);
            ls_drv_en[g] = port_en[g] && port_ls[g] && ls_open;
        end
    end

endmodule

// File: rtl/rpt_frame_timer.sv
// Frame timer: counts full-speed bit ticks, restarts on a frame-start token.
// Assumes: bit_tick is a one-cycle enable at the full-speed bit rate.
module rpt_frame_timer #(
    parameter int FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               sof_rx,
    output logic [FRAME_W-1:0] frame_cnt
);

    logic [FRAME_W-1:0] cnt_q;

    // Clear on frame start, otherwise step on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sof_rx) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_cnt = cnt_q;

    p_sof_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_rx |=> (frame_cnt == '0));

    p_tick_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_rx && bit_tick) |=> (frame_cnt == $past(frame_cnt) + 1'b1));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_rx && !bit_tick) |=> $stable(frame_cnt));

endmodule

// File: rtl/hub_rpt_ctl.sv
// Hub repeat control top: decides per downstream port whether upstream
// traffic is repeated and whether low-speed drivers are on, and runs the
// frame timer.
// Assumes: all inputs synchronous to clk; one bit_tick per full-speed bit.
module hub_rpt_ctl #(
    parameter int NPORTS  = 4,
    parameter int FRAME_W = 14,
    parameter int LS_GAP  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic [NPORTS-1:0]  port_en,
    input  logic [NPORTS-1:0]  port_ls,
    input  logic               sop,
    input  logic [7:0]         pid,
    input  logic               pid_vld,
    input  logic               eop,
    input  logic               sof_rx,
    output logic [NPORTS-1:0]  rpt_en,
    output logic [NPORTS-1:0]  ls_drv_en,
    output logic [FRAME_W-1:0] frame_cnt
);

    logic fs_open;
    logic ls_open;

    rpt_seq #(
        .LS_GAP (LS_GAP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .sop      (sop),
        .pid      (pid),
        .pid_vld  (pid_vld),
        .eop      (eop),
        .fs_open  (fs_open),
        .ls_open  (ls_open)
    );

    rpt_port_gate #(
        .NPORTS (NPORTS)
    ) u_gate (
        .port_en   (port_en),
        .port_ls   (port_ls),
        .fs_open   (fs_open),
        .ls_open   (ls_open),
        .rpt_en    (rpt_en),
        .ls_drv_en (ls_drv_en)
    );

    rpt_frame_timer #(
        .FRAME_W (FRAME_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .sof_rx    (sof_rx),
        .frame_cnt (frame_cnt)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_chk
        p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en[g] |-> (!rpt_en[g] && !ls_drv_en[g]));

        p_ls_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (port_ls[g] && !ls_open) |-> (!rpt_en[g] && !ls_drv_en[g]));

        p_no_fs_on_ls_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (port_ls[g] && rpt_en[g]) |-> ls_drv_en[g]);
    end

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rpt_en == '0 && ls_drv_en == '0 && frame_cnt == '0));

endmodule

// File: tb/tb_hub_rpt_ctl.sv
module tb_hub_rpt_ctl;

    localparam int NP = 4;
    localparam int FW = 14;
    localparam int GAP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic [NP-1:0] port_en = '0;
    logic [NP-1:0] port_ls = '0;
    logic          sop = 1'b0;
    logic [7:0]    pid = '0;
    logic          pid_vld = 1'b0;
    logic          eop = 1'b0;
    logic          sof_rx = 1'b0;
    logic [NP-1:0] rpt_en;
    logic [NP-1:0] ls_drv_en;
    logic [FW-1:0] frame_cnt;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // Bench model: 0 closed, 1 full-speed, 2 waiting after preamble, 3 low-speed open
    int            m_st = 0;
    int            m_gap = 0;
    logic [FW-1:0] m_frame = '0;

    hub_rpt_ctl #(.NPORTS(NP), .FRAME_W(FW), .LS_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .port_en(port_en),
        .port_ls(port_ls), .sop(sop), .pid(pid), .pid_vld(pid_vld), .eop(eop),
        .sof_rx(sof_rx), .rpt_en(rpt_en), .ls_drv_en(ls_drv_en), .frame_cnt(frame_cnt)
    );

    always #10 clk = ~clk;

    function automatic logic [NP-1:0] exp_rpt(int st, logic [NP-1:0] en, logic [NP-1:0] ls);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = en[i] && (ls[i] ? (st == 3) : (st != 0));
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_ls(int st, logic [NP-1:0] en, logic [NP-1:0] ls);
        return (st == 3) ? (en & ls) : '0;
    endfunction

    task automatic check(input string tag);
        logic [NP-1:0] er;
        logic [NP-1:0] el;
        er = exp_rpt(m_st, port_en, port_ls);
        el = exp_ls(m_st, port_en, port_ls);
        checks += 3;
        if (rpt_en !== er) begin
            fails++;
            $display("FAIL %s rpt_en got %b exp %b", tag, rpt_en, er);
        end
        if (ls_drv_en !== el) begin
            fails++;
            $display("FAIL %s ls_drv_en got %b exp %b", tag, ls_drv_en, el);
        end
        if (frame_cnt !== m_frame) begin
            fails++;
            $display("FAIL %s frame_cnt got %0d exp %0d", tag, frame_cnt, m_frame);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_gap = 0; m_frame = '0;
        end else begin
            if (sof_rx) m_frame = '0;
            else if (bit_tick) m_frame = m_frame + 1'b1;
            case (m_st)
                0: if (sop && !eop) m_st = 1;
                1: if (eop) m_st = 0;
                   else if (pid_vld && pid == 8'h3C) begin m_st = 2; m_gap = 0; end
                2: if (eop) begin m_st = 0; m_gap = 0; end
                   else if (bit_tick) begin
                       if (m_gap == GAP - 1) begin m_st = 3; m_gap = 0; end
                       else m_gap++;
                   end
                default: if (eop) m_st = 0;
            endcase
        end
    endtask

    // One cycle: check at the falling edge, then advance the model at the rising edge.
    task automatic cycle(input string tag);
        #1;
        check(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        sop = 0; pid_vld = 0; eop = 0; sof_rx = 0; bit_tick = 0; pid = 8'h00;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        @(posedge clk); model_step();
        @(posedge clk); model_step();
        @(negedge clk);
        rst_n = 1;
        cycle("R9 reset state");

        // Directed: port0 FS on, port1 LS on, port2 FS on, port3 LS off
        port_en = 4'b0111; port_ls = 4'b1010;
        cycle("R2 closed idle");
        sop = 1; cycle("R1 sop"); quiet();
        cycle("R1 full-speed open");
        pid = 8'h3C; cycle("R3 preamble without strobe");
        pid = 8'h2D; pid_vld = 1; cycle("R3 other pid"); quiet();
        cycle("R2 low-speed still closed");
        pid = 8'h3C; pid_vld = 1; cycle("R3 preamble strobe"); quiet();
        for (int k = 0; k < 3; k++) begin cycle("R4 before gap"); end
        for (int k = 0; k < GAP + 2; k++) begin bit_tick = 1; cycle("R4 gap ticks"); end
        quiet();
        sop = 1; cycle("R10 sop while open"); quiet();
        cycle("R10 still open");
        eop = 1; cycle("R5 eop"); quiet();
        cycle("R5 closed");
        // eop together with preamble strobe
        sop = 1; cycle("R1 sop again"); quiet();
        pid = 8'h3C; pid_vld = 1; eop = 1; cycle("R10 eop beats preamble"); quiet();
        for (int k = 0; k < GAP + 1; k++) begin bit_tick = 1; cycle("R10 stays closed"); end
        quiet();
        // eop during the wait window
        sop = 1; cycle("R1 sop"); quiet();
        pid = 8'h3C; pid_vld = 1; cycle("R3 strobe"); quiet();
        bit_tick = 1; cycle("R4 tick"); quiet();
        eop = 1; cycle("R5 eop in wait"); quiet();
        for (int k = 0; k < GAP + 1; k++) begin bit_tick = 1; cycle("R5 wait aborted"); end
        quiet();
        // disabled ports during a low-speed packet
        sop = 1; cycle("R6 sop"); quiet();
        pid = 8'h3C; pid_vld = 1; cycle("R6 strobe"); quiet();
        for (int k = 0; k < GAP; k++) begin bit_tick = 1; cycle("R6 ticks"); end
        quiet();
        port_en = 4'b0000; port_ls = 4'b1111; cycle("R6 all disabled ls");
        port_ls = 4'b0000; cycle("R6 all disabled fs");
        port_en = 4'b1111; port_ls = 4'b0110; cycle("R1 mixed in low-speed packet");
        eop = 1; cycle("R5 close"); quiet();
        // frame timer
        sof_rx = 1; bit_tick = 1; cycle("R8 sof with tick"); quiet();
        cycle("R8 cleared");
        for (int k = 0; k < (1 << FW) + 5; k++) begin bit_tick = 1; cycle("R7 wrap"); end
        quiet();
        cycle("R7 hold");
        // reset mid-run with nonzero timer and an open packet
        sop = 1; cycle("R9 pre"); quiet();
        rst_n = 0; cycle("R9 in reset");
        rst_n = 1; cycle("R9 after reset");

        // Constrained random
        for (int n = 0; n < 6000; n++) begin
            if (n % 64 == 0) begin
                port_en = 4'($urandom);
                port_ls = 4'($urandom);
            end
            sop      = ($urandom % 8) == 0;
            pid_vld  = ($urandom % 6) == 0;
            pid      = (($urandom % 3) == 0) ? 8'h3C : 8'($urandom);
            eop      = ($urandom % 20) == 0;
            sof_rx   = ($urandom % 300) == 0;
            bit_tick = ($urandom % 4) == 0;
            cycle("R1/R4/R7 random");
        end
        quiet();
        cycle("R5 random end");
        finish_run();
    end

endmodule